// File: doc/BRIEF.md
# Pipelined Float-to-Integer Converter

This block turns a single-precision IEEE-754 value into a signed 32-bit two's-complement integer. Each conversion uses one of four rounding directions, chosen per input by a 2-bit mode field. The block is pipelined and accepts one value per clock. Each result leaves exactly three cycles after its input, with a flag that marks conversions that cannot be represented.

The first stage splits the word into sign, biased exponent and fraction. Inputs whose magnitude is below one, and inputs whose exponent is out of range, are settled in this stage by exponent thresholds alone. For all other inputs the first stage also works out the alignment distance. The second stage restores the hidden one and shifts the significand right. It keeps a guard bit and a round bit, and folds every bit that falls off the end into a sticky bit. The third stage applies the rounding increment, checks again for overflow, and negates the magnitude when the sign is set. Out-of-range results saturate to the most negative integer.

Top module: `f2i_conv`

## Requirements
- R1: `out_valid` rises exactly three clock edges after the edge that samples `in_valid` high, one result per accepted input, back-to-back inputs included. Synchronous reset clears `out_valid`, `out_int` and `out_invalid` to zero and drops any conversions still in flight.
- R2: Mode encoding is 00 toward zero, 01 toward minus infinity, 10 toward plus infinity, 11 nearest with ties to even. Inputs that are whole numbers convert exactly (100.0 gives 0x00000064).
- R3: A biased exponent of 158 or more, which covers infinities and NaNs, sets `out_invalid` and gives 0x80000000. The one exception is the case in R4.
- R4: Exactly -2^31 (0xCF000000) gives 0x80000000 with `out_invalid` low, in every mode.
- R5: For nonzero magnitudes below one, the directed modes work as follows. Toward zero gives 0. Toward minus infinity gives -1 (0xFFFFFFFF) for negative inputs and 0 for positive inputs. Toward plus infinity gives +1 for positive inputs and 0 for negative inputs. Both signed zeros give 0 in every mode.
- R6: Under nearest-even, magnitudes below one half give 0. Exactly one half also gives 0. Magnitudes strictly between one half and one give +1 or -1.
- R7: For magnitudes of one or more, the fractional part is rounded by the selected mode. For example, 2.5 gives 2/2/3/2 in modes 00/01/10/11, -2.5 gives -2/-3/-2/-2, and 3.5 and 1.5 under nearest-even give 4 and 2.
- R8: Fraction bits below the round position still count toward rounding. Under nearest-even, 0x40200001 (just above 2.5) gives 3.
- R9: A negative input yields the two's complement of its rounded magnitude. For example, -1.0 gives 0xFFFFFFFF and 0xCEFFFFFF gives 0x80000080. A nonzero valid result carries the sign of its input.
- R10: The largest float below 2^31 (0x4EFFFFFF) gives 0x7FFFFF80 with `out_invalid` low. +2^31 (0x4F000000) is invalid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input word and mode are to be converted |
| in_bits | input | 32 | Single-precision operand |
| in_mode | input | 2 | Rounding direction (see R2) |
| out_valid | output | 1 | Result registers hold a new conversion |
| out_int | output | 32 | Two's-complement result |
| out_invalid | output | 1 | Input could not be represented; result saturated |

## Verification
Corruption of a stage register shows at the ports three edges after the affected input at the latest. A lost valid bit shows as a missing or extra `out_valid` pulse. A wrong shift amount, guard bit or sticky bit shows as a result off by one or off by a power of two. A stale sign shows as a result of the wrong polarity. The stimulus streams back-to-back so that state leaking between neighbouring inputs appears at once. It also puts the values on either side of each exponent threshold (one half, one, 2^31) through every mode, where an off-by-one compare changes the integer or the flag.

// File: rtl/f2i_pkg.sv
`timescale 1ns/1ps
package f2i_pkg;

    localparam int FW    = 32;
    localparam int EXPW  = 8;
    localparam int MANW  = 23;
    localparam int IW    = 32;
    localparam int BIAS  = 127;
    localparam int GRS   = 3;
    localparam int MAGW  = IW - 1;
    localparam int ALNW  = MAGW + GRS;
    localparam int SHW   = $clog2(MAGW);
    localparam int PADW  = ALNW - MANW - 1;

    localparam logic [EXPW-1:0] EXP_ONE  = EXPW'(BIAS);
    localparam logic [EXPW-1:0] EXP_HALF = EXPW'(BIAS - 1);
    localparam logic [EXPW-1:0] EXP_TOP  = EXPW'(BIAS + MAGW - 1);
    localparam logic [EXPW-1:0] EXP_OVF  = EXPW'(BIAS + MAGW);

    localparam logic [IW-1:0] INT_MIN = {1'b1, {(IW-1){1'b0}}};

    typedef enum logic [1:0] {
        RND_ZERO = 2'b00,
        RND_DOWN = 2'b01,
        RND_UP   = 2'b10,
        RND_EVEN = 2'b11
    } rnd_mode_t;

    typedef struct packed {
        logic              neg;
        rnd_mode_t         mode;
        logic              done;
        logic              bad;
        logic [IW-1:0]     fixed;
        logic [SHW-1:0]    shamt;
        logic [MANW-1:0]   frac;
    } dec_t;

    typedef struct packed {
        logic              neg;
        rnd_mode_t         mode;
        logic              done;
        logic              bad;
        logic [IW-1:0]     fixed;
        logic [MAGW-1:0]   whole;
        logic              g;
        logic              r;
        logic              s;
    } aln_t;

    function automatic logic [IW-1:0] signed_one(input logic neg);
        return neg ? {IW{1'b1}} : IW'(1);
    endfunction

    function automatic logic round_up(input rnd_mode_t m, input logic neg,
                                      input logic lsb, input logic g,
                                      input logic r, input logic s);
        logic inexact;
        inexact = g | r | s;
        case (m)
            RND_DOWN: return neg & inexact;
            RND_UP:   return ~neg & inexact;
            RND_EVEN: return g & (r | s | lsb);
            default:  return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/f2i_classify.sv
`timescale 1ns/1ps
module f2i_classify
    import f2i_pkg::*;
(
    input  logic [FW-1:0] x,
    input  rnd_mode_t     mode,
    output dec_t          d
);
    logic            neg;
    logic [EXPW-1:0] expo;
    logic [MANW-1:0] frac;
    logic            is_zero;
    logic            min_exact;

    assign neg       = x[FW-1];
    assign expo      = x[FW-2 -: EXPW];
    assign frac      = x[MANW-1:0];
    assign is_zero   = (expo == '0) && (frac == '0);
    assign min_exact = neg && (expo == EXP_OVF) && (frac == '0);

    always_comb begin
        d.neg   = neg;
        d.mode  = mode;
        d.frac  = frac;
        d.shamt = SHW'(EXP_TOP - expo);
        d.done  = 1'b0;
        d.bad   = 1'b0;
        d.fixed = '0;
        if (expo >= EXP_OVF) begin
            d.done  = 1'b1;
            d.fixed = INT_MIN;
            d.bad   = !min_exact;
        end else if (expo < EXP_ONE) begin
            d.done = 1'b1;
            if (!is_zero) begin
                case (mode)
                    RND_DOWN: if (neg)  d.fixed = signed_one(1'b1);
                    RND_UP:   if (!neg) d.fixed = signed_one(1'b0);
                    RND_EVEN: if ((expo == EXP_HALF) && (frac != '0))
                                  d.fixed = signed_one(neg);
                    default:  d.fixed = '0;
                endcase
            end
        end
    end
endmodule

// File: rtl/f2i_align.sv
`timescale 1ns/1ps
module f2i_align
    import f2i_pkg::*;
(
    input  dec_t d,
    output aln_t a
);
    logic [ALNW-1:0] base;
    logic [ALNW-1:0] shifted;
    logic [ALNW-1:0] lost_mask;
    logic            lost;

    assign base      = {1'b1, d.frac, {PADW{1'b0}}};
    assign shifted   = base >> d.shamt;
    assign lost_mask = ~({ALNW{1'b1}} << d.shamt);
    assign lost      = |(base & lost_mask);

    always_comb begin
        a.neg   = d.neg;
        a.mode  = d.mode;
        a.done  = d.done;
        a.bad   = d.bad;
        a.fixed = d.fixed;
        a.whole = shifted[ALNW-1:GRS];
        a.g     = shifted[GRS-1];
        a.r     = shifted[GRS-2];
        a.s     = shifted[0] | lost;
    end
endmodule

// File: rtl/f2i_round.sv
`timescale 1ns/1ps
module f2i_round
    import f2i_pkg::*;
(
    input  aln_t          a,
    output logic [IW-1:0] result,
    output logic          bad
);
    logic          up;
    logic [IW-1:0] mag;
    logic          ovf;

    assign up  = round_up(a.mode, a.neg, a.whole[0], a.g, a.r, a.s);
    assign mag = {1'b0, a.whole} + IW'(up);
    assign ovf = a.neg ? (mag[IW-1] && (mag[IW-2:0] != '0)) : mag[IW-1];

    always_comb begin
        if (a.done) begin
            result = a.fixed;
            bad    = a.bad;
        end else if (ovf) begin
            result = INT_MIN;
            bad    = 1'b1;
        end else begin
            result = a.neg ? (~mag + IW'(1)) : mag;
            bad    = 1'b0;
        end
    end
endmodule

// File: rtl/f2i_conv.sv
`timescale 1ns/1ps
module f2i_conv
    import f2i_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          in_valid,
    input  logic [31:0]   in_bits,
    input  logic [1:0]    in_mode,
    output logic          out_valid,
    output logic [31:0]   out_int,
    output logic          out_invalid
);
    dec_t          dec_c, dec_q;
    aln_t          aln_c, aln_q;
    logic          dec_v, aln_v;
    logic [IW-1:0] res_c;
    logic          bad_c;

    f2i_classify u_classify (
        .x    (in_bits),
        .mode (rnd_mode_t'(in_mode)),
        .d    (dec_c)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            dec_v <= 1'b0;
            dec_q <= '0;
        end else begin
            dec_v <= in_valid;
            if (in_valid) dec_q <= dec_c;
        end
    end

    f2i_align u_align (
        .d (dec_q),
        .a (aln_c)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            aln_v <= 1'b0;
            aln_q <= '0;
        end else begin
            aln_v <= dec_v;
            if (dec_v) aln_q <= aln_c;
        end
    end

    f2i_round u_round (
        .a      (aln_q),
        .result (res_c),
        .bad    (bad_c)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid   <= 1'b0;
            out_int     <= '0;
            out_invalid <= 1'b0;
        end else begin
            out_valid <= aln_v;
            if (aln_v) begin
                out_int     <= res_c;
                out_invalid <= bad_c;
            end
        end
    end
endmodule

// File: rtl/f2i_conv_chk.sv
`timescale 1ns/1ps
module f2i_conv_chk (
    input logic        clk,
    input logic        rst,
    input logic        in_valid,
    input logic [31:0] in_bits,
    input logic [1:0]  in_mode,
    input logic        out_valid,
    input logic [31:0] out_int,
    input logic        out_invalid
);
    logic [1:0] warm;
    always_ff @(posedge clk) begin
        if (rst)               warm <= '0;
        else if (warm != 2'd3) warm <= warm + 2'd1;
    end

    // R1
    latency_chk: assert property (@(posedge clk) disable iff (rst)
        (warm == 2'd3) |-> (out_valid == $past(in_valid, 3)));

    // R3
    sat_value_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_invalid) |-> (out_int == 32'h8000_0000));

    // R3
    nan_inf_chk: assert property (@(posedge clk) disable iff (rst)
        ((warm == 2'd3) && $past(in_valid && (in_bits[30:23] == 8'hFF), 3))
        |-> (out_valid && out_invalid));

    // R4
    int_min_chk: assert property (@(posedge clk) disable iff (rst)
        ((warm == 2'd3) && $past(in_valid && (in_bits == 32'hCF00_0000), 3))
        |-> (out_valid && !out_invalid && (out_int == 32'h8000_0000)));

    // R5
    trunc_small_chk: assert property (@(posedge clk) disable iff (rst)
        ((warm == 2'd3) && $past(in_valid && (in_mode == 2'b00)
                                 && (in_bits[30:23] < 8'd127), 3))
        |-> (out_int == 32'd0));

    // R9
    sign_follow_chk: assert property (@(posedge clk) disable iff (rst)
        ((warm == 2'd3) && out_valid && !out_invalid && (out_int != 32'd0))
        |-> (out_int[31] == $past(in_bits[31], 3)));
endmodule

bind f2i_conv f2i_conv_chk u_chk (.*);

// File: tb/f2i_conv_test.sv
`timescale 1ns/1ps
module f2i_conv_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [31:0] in_bits = '0;
    logic [1:0]  in_mode = '0;
    logic        out_valid;
    logic [31:0] out_int;
    logic        out_invalid;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    f2i_conv uut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_bits(in_bits),
        .in_mode(in_mode), .out_valid(out_valid), .out_int(out_int),
        .out_invalid(out_invalid)
    );

    // {req, mode, bits, invalid, expected}
    localparam int NV = 38;
    localparam logic [70:0] VEC [NV] = '{
        {4'd2,  2'd0, 32'h3F800000, 1'b0, 32'h00000001},  // R2 1.0
        {4'd2,  2'd0, 32'h42C80000, 1'b0, 32'h00000064},  // R2 100.0
        {4'd9,  2'd0, 32'hBF800000, 1'b0, 32'hFFFFFFFF},  // R9 -1.0
        {4'd7,  2'd0, 32'h40200000, 1'b0, 32'h00000002},  // R7 2.5
        {4'd7,  2'd1, 32'h40200000, 1'b0, 32'h00000002},
        {4'd7,  2'd2, 32'h40200000, 1'b0, 32'h00000003},
        {4'd7,  2'd3, 32'h40200000, 1'b0, 32'h00000002},
        {4'd7,  2'd3, 32'h40600000, 1'b0, 32'h00000004},  // R7 3.5
        {4'd7,  2'd3, 32'hC0200000, 1'b0, 32'hFFFFFFFE},  // R7 -2.5
        {4'd7,  2'd1, 32'hC0200000, 1'b0, 32'hFFFFFFFD},
        {4'd7,  2'd2, 32'hC0200000, 1'b0, 32'hFFFFFFFE},
        {4'd7,  2'd0, 32'hC0200000, 1'b0, 32'hFFFFFFFE},
        {4'd7,  2'd3, 32'h3FC00000, 1'b0, 32'h00000002},  // R7 1.5
        {4'd8,  2'd3, 32'h40200001, 1'b0, 32'h00000003},  // R8 sticky
        {4'd6,  2'd3, 32'h3F000000, 1'b0, 32'h00000000},  // R6 0.5
        {4'd6,  2'd3, 32'h3F400000, 1'b0, 32'h00000001},  // R6 0.75
        {4'd6,  2'd3, 32'hBF400000, 1'b0, 32'hFFFFFFFF},
        {4'd6,  2'd3, 32'h3E800000, 1'b0, 32'h00000000},  // R6 0.25
        {4'd5,  2'd2, 32'h3F000000, 1'b0, 32'h00000001},  // R5
        {4'd5,  2'd1, 32'h3F000000, 1'b0, 32'h00000000},
        {4'd5,  2'd0, 32'hBF400000, 1'b0, 32'h00000000},
        {4'd5,  2'd2, 32'h3E800000, 1'b0, 32'h00000001},
        {4'd5,  2'd1, 32'hBE800000, 1'b0, 32'hFFFFFFFF},
        {4'd5,  2'd2, 32'hBE800000, 1'b0, 32'h00000000},
        {4'd5,  2'd1, 32'h00000000, 1'b0, 32'h00000000},  // R5 +0
        {4'd5,  2'd1, 32'h80000000, 1'b0, 32'h00000000},  // R5 -0
        {4'd5,  2'd2, 32'h80000000, 1'b0, 32'h00000000},
        {4'd5,  2'd2, 32'h00000001, 1'b0, 32'h00000001},  // R5 tiny
        {4'd5,  2'd1, 32'h80000001, 1'b0, 32'hFFFFFFFF},
        {4'd3,  2'd0, 32'h7F800000, 1'b1, 32'h80000000},  // R3 +inf
        {4'd3,  2'd3, 32'h7FC00000, 1'b1, 32'h80000000},  // R3 NaN
        {4'd3,  2'd2, 32'hFF800000, 1'b1, 32'h80000000},  // R3 -inf
        {4'd10, 2'd0, 32'h4F000000, 1'b1, 32'h80000000},  // R10 2^31
        {4'd3,  2'd0, 32'hCF000001, 1'b1, 32'h80000000},
        {4'd4,  2'd0, 32'hCF000000, 1'b0, 32'h80000000},  // R4
        {4'd4,  2'd3, 32'hCF000000, 1'b0, 32'h80000000},
        {4'd10, 2'd3, 32'h4EFFFFFF, 1'b0, 32'h7FFFFF80},  // R10
        {4'd9,  2'd1, 32'hCEFFFFFF, 1'b0, 32'h80000080}   // R9
    };

    task automatic check(input string tag, input string what,
                         input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s %s: got %h expected %h", tag, what, got, exp);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1", "out_valid in reset", 32'(out_valid), 32'd0);
        check("R1", "out_int in reset", out_int, 32'd0);
        check("R1", "out_invalid in reset", 32'(out_invalid), 32'd0);
        rst = 1'b0;

        // stream the table back to back
        for (int i = 0; i < NV + 3; i++) begin
            @(negedge clk);
            if (i < NV) begin
                in_valid = 1'b1;
                in_mode  = VEC[i][66:65];
                in_bits  = VEC[i][64:33];
            end else begin
                in_valid = 1'b0;
            end
            if (i >= 3) begin
                string tag;
                tag = $sformatf("R%0d", VEC[i-3][70:67]);
                check("R1", $sformatf("valid for vector %0d", i-3),
                      32'(out_valid), 32'd1);
                check(tag, $sformatf("int for vector %0d", i-3),
                      out_int, VEC[i-3][31:0]);
                check(tag, $sformatf("flag for vector %0d", i-3),
                      32'(out_invalid), 32'(VEC[i-3][32]));
            end
        end

        // R1 no output when idle
        @(negedge clk);
        check("R1", "idle out_valid", 32'(out_valid), 32'd0);

        // R1 single isolated input lands on the third edge
        in_valid = 1'b1; in_mode = 2'b00; in_bits = 32'h42C80000;
        @(negedge clk); in_valid = 1'b0;
        @(negedge clk);
        check("R1", "valid before third edge", 32'(out_valid), 32'd0);
        @(negedge clk);
        check("R1", "valid on third edge", 32'(out_valid), 32'd1);
        check("R2", "isolated 100.0", out_int, 32'h00000064);

        // R1 reset drops in-flight work
        @(negedge clk);
        in_valid = 1'b1; in_mode = 2'b10; in_bits = 32'h40200000;
        @(negedge clk); in_valid = 1'b0; rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        @(negedge clk);
        check("R1", "flushed valid", 32'(out_valid), 32'd0);
        check("R1", "flushed int", out_int, 32'd0);
        @(negedge clk);
        check("R1", "flushed valid later", 32'(out_valid), 32'd0);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(5.0 * 200000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule